// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block is a purely combinational 16-bit binary adder that adds two operands and a carry input. It splits the operand width into four 4-bit slices. Each slice forms a local generate (both operand bits set) and a local propagate (either operand bit set) for every position. It then computes all of its internal carries as flat sum-of-products expressions of those terms and its own slice carry input.

A second lookahead stage works on the four slice-level generate and propagate summaries. From these and the adder's carry input it produces the carry input of every slice in a single flat step, so no carry passes serially from slice to slice. The same stage exports a 16-bit-wide generate and propagate pair, which lets a wider adder place this block under a third lookahead level. The carry into the fifth slice position is the adder's carry out.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in`, taken as unsigned numbers.
- R2: `carry_out` equals bit 16 of the 17-bit unsigned result of `op_a + op_b + carry_in`.
- R3: The carry entering the slices at bits 4, 8 and 12 equals the carry out of the unsigned addition of the operand bits below that position plus `carry_in`.
- R4: With every bit position propagating and none generating (for example 0xFFFF plus 0x0000), `carry_in` = 1 reaches `carry_out` and leaves `sum` = 0x0000, and `carry_in` = 0 gives `sum` = 0xFFFF and `carry_out` = 0.
- R5: 0xFFFF plus 0x0001 with `carry_in` = 0 gives `sum` = 0x0000 and `carry_out` = 1.
- R6: `blk_gen` is 1 exactly when `op_a + op_b` with no carry input overflows 16 bits.
- R7: `blk_prop` is 1 exactly when every one of the 16 bit positions has at least one operand bit set, i.e. `&(op_a | op_b)`.
- R8: `carry_out` always equals `blk_gen | (blk_prop & carry_in)`.
- R9: A carry born in one slice and carried through the full width of the slices above it (for example 0x0FFF plus 0x0001, or 0x00F8 plus 0x0008) gives the same result as the plain 17-bit sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Whole-width generate: the operands alone produce a carry out |
| blk_prop | output | 1 | Whole-width propagate: every position passes a carry |

## Verification
The bench goes after carries that must cross slice boundaries: an incoming carry driven through all sixteen propagating positions, all-ones plus one, and carries born low in one slice that must cross one or more whole slices above. A slice carry term with a missing product shows up as a wrong bit at 4, 8 or 12 or a lost carry out. The block-level terms are checked on their own. A generate term built from the OR propagate in the wrong order, or a propagate that misses one slice, shows up as a wrong `blk_gen` or `blk_prop` even when the sum is right. Random operand pairs with both carry input values fill in the general case.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int GRP_W = 4;
  localparam int N_GRP = 4;
  localparam int ADD_W = GRP_W * N_GRP;

  // Flat lookahead over four generate/propagate pairs.
  // Returns {c4, c3, c2, c1, c0}; c0 is the incoming carry.
  function automatic logic [4:0] la_carries(input logic [3:0] g,
                                            input logic [3:0] p,
                                            input logic       c0);
    logic [4:0] c;
    c[0] = c0;
    c[1] = g[0] | (p[0] & c0);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
         | (p[2] & p[1] & p[0] & c0);
    c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
         | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & c0);
    return c;
  endfunction

  // Summary of four positions: {generate, propagate}.
  function automatic logic [1:0] la_summary(input logic [3:0] g,
                                            input logic [3:0] p);
    logic gs;
    logic ps;
    ps = &p;
    gs = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
       | (p[3] & p[2] & p[1] & g[0]);
    return {gs, ps};
  endfunction

endpackage

// File: rtl/cla_group4.sv
module cla_group4
  import cla_pkg::*;
(
  input  logic [GRP_W-1:0] a,
  input  logic [GRP_W-1:0] b,
  input  logic             c_in,
  output logic [GRP_W-1:0] s,
  output logic             grp_g,
  output logic             grp_p
);

  logic [GRP_W-1:0] bit_g;
  logic [GRP_W-1:0] bit_p;
  logic [GRP_W:0]   bit_c;
  logic [1:0]       summ;

  always_comb begin
    bit_g = a & b;
    bit_p = a | b;
    bit_c = la_carries(bit_g, bit_p, c_in);
    summ  = la_summary(bit_g, bit_p);
    s     = a ^ b ^ bit_c[GRP_W-1:0];
    grp_g = summ[1];
    grp_p = summ[0];
  end

endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4
  import cla_pkg::*;
(
  input  logic [N_GRP-1:0] g_in,
  input  logic [N_GRP-1:0] p_in,
  input  logic             c_in,
  output logic [N_GRP:0]   c_out,
  output logic             top_g,
  output logic             top_p
);

  logic [1:0] summ;

  always_comb begin
    c_out = la_carries(g_in, p_in, c_in);
    summ  = la_summary(g_in, p_in);
    top_g = summ[1];
    top_p = summ[0];
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
(
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  output logic [15:0] sum,
  output logic        carry_out,
  output logic        blk_gen,
  output logic        blk_prop
);

  // Named slice-level events, visible to the checker.
  logic [N_GRP-1:0] slice_g;
  logic [N_GRP-1:0] slice_p;
  logic [N_GRP:0]   slice_cin;

  for (genvar k = 0; k < N_GRP; k++) begin : g_slice
    cla_group4 u_grp (
      .a     (op_a[k*GRP_W +: GRP_W]),
      .b     (op_b[k*GRP_W +: GRP_W]),
      .c_in  (slice_cin[k]),
      .s     (sum[k*GRP_W +: GRP_W]),
      .grp_g (slice_g[k]),
      .grp_p (slice_p[k])
    );
  end

  cla_lookahead4 u_la (
    .g_in  (slice_g),
    .p_in  (slice_p),
    .c_in  (carry_in),
    .c_out (slice_cin),
    .top_g (blk_gen),
    .top_p (blk_prop)
  );

  assign carry_out = slice_cin[N_GRP];

endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk (
  input logic [15:0] a,
  input logic [15:0] b,
  input logic        ci,
  input logic [15:0] s,
  input logic        co,
  input logic        bg,
  input logic        bp,
  input logic [4:0]  sc
);

  logic [16:0] full;
  logic [16:0] nocarry;
  logic [4:0]  lo4;
  logic [8:0]  lo8;
  logic [12:0] lo12;

  always_comb begin
    full    = {1'b0, a} + {1'b0, b} + {16'd0, ci};
    nocarry = {1'b0, a} + {1'b0, b};
    lo4     = {1'b0, a[3:0]}  + {1'b0, b[3:0]}  + {4'd0, ci};
    lo8     = {1'b0, a[7:0]}  + {1'b0, b[7:0]}  + {8'd0, ci};
    lo12    = {1'b0, a[11:0]} + {1'b0, b[11:0]} + {12'd0, ci};

    a_r1_sum: assert ({co, s} == full)
      else $error("sum/carry mismatch");
    a_r3_slice1: assert (sc[1] == lo4[4])
      else $error("carry into bit 4 wrong");
    a_r3_slice2: assert (sc[2] == lo8[8])
      else $error("carry into bit 8 wrong");
    a_r3_slice3: assert (sc[3] == lo12[12])
      else $error("carry into bit 12 wrong");
    a_r6_blk_gen: assert (bg == nocarry[16])
      else $error("block generate wrong");
    a_r7_blk_prop: assert (bp == &(a | b))
      else $error("block propagate wrong");
    a_r8_cout_rel: assert (co == (bg | (bp & ci)))
      else $error("carry out disagrees with block terms");
  end

endmodule

bind cla_adder16 cla_adder16_chk u_chk (
  .a  (op_a),
  .b  (op_b),
  .ci (carry_in),
  .s  (sum),
  .co (carry_out),
  .bg (blk_gen),
  .bp (blk_prop),
  .sc (slice_cin)
);

// File: tb/sim_cla_adder16.sv
`timescale 1ns/1ps
module sim_cla_adder16;

  typedef struct {
    logic [15:0] s;
    logic        co;
    logic        g;
    logic        p;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum;
  logic        carry_out;
  logic        blk_gen;
  logic        blk_prop;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t sb[$];
  bit   drv_done = 0;

  always #2.5 clk = ~clk;

  cla_adder16 u0 (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out),
    .blk_gen(blk_gen), .blk_prop(blk_prop)
  );

  task automatic chk1(input string rq, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Driver: apply on the falling edge, push the expected item.
  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input string tag);
    logic [16:0] tot;
    logic [16:0] raw;
    exp_t e;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    tot = 17'(a) + 17'(b) + 17'(ci);
    raw = 17'(a) + 17'(b);
    e.s = tot[15:0];
    e.co = tot[16];
    e.g = raw[16];
    e.p = &(a | b);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: combinational result is settled by the next rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk1({e.tag, "/R1"}, "sum", sum, e.s);
        chk1({e.tag, "/R2"}, "carry_out", 16'(carry_out), 16'(e.co));
        chk1({e.tag, "/R6"}, "blk_gen", 16'(blk_gen), 16'(e.g));
        chk1({e.tag, "/R7"}, "blk_prop", 16'(blk_prop), 16'(e.p));
        chk1({e.tag, "/R8"}, "cout_rel", 16'(carry_out),
             16'(blk_gen | (blk_prop & carry_in)));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset-time state with zero operands.
    chk1("RST", "sum", sum, 16'h0000);
    chk1("RST", "carry_out", 16'(carry_out), 16'h0);
    rst_n = 1'b1;

    drive(16'hFFFF, 16'h0000, 1'b1, "R4 all-prop cin1");
    drive(16'hFFFF, 16'h0000, 1'b0, "R4 all-prop cin0");
    drive(16'h5555, 16'hAAAA, 1'b1, "R4 alt-prop cin1");
    drive(16'hFFFF, 16'h0001, 1'b0, "R5 ones+1");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R5 ones+ones+1");
    drive(16'h0FFF, 16'h0001, 1'b0, "R9 R3 cross3");
    drive(16'h00F8, 16'h0008, 1'b0, "R9 R3 cross1");
    drive(16'h000F, 16'h0000, 1'b1, "R3 slice0 out");
    drive(16'h00FF, 16'h0000, 1'b1, "R3 slice1 out");
    drive(16'h0FFF, 16'h0000, 1'b1, "R3 slice2 out");
    drive(16'h8000, 16'h8000, 1'b0, "R6 top gen");
    drive(16'hFFFE, 16'h0000, 1'b1, "R7 one kill");
    drive(16'h0000, 16'h0000, 1'b0, "R1 zero");
    for (int i = 0; i < 400; i++)
      drive(16'($urandom), 16'($urandom), 1'($urandom), "R1 R2 rand");
    @(negedge clk);
    drv_done = 1;
  end

  initial begin
    fork
      begin
        wait (drv_done && sb.size() == 0);
        @(posedge clk);
        #2;
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule